// File: doc/BRIEF.md
# Two-Beat Sample Output Formatter

This block sits behind a 14-bit converter and drives the results onto a narrow 8-bit output bus. Each result enters on a sample strobe together with a small channel tag. A fixed-depth pipeline holds it for a set number of clocks. A three-state sequencer then sends the result as two beats on consecutive clocks. The first beat carries the eight most significant bits. The second beat carries the six least significant bits on the upper six lanes and zeros on the two lowest lanes.

A beat flag separates the two halves, so a receiver can rebuild the word. A valid strobe and the tag travel with both beats. An active-low output enable models a three-state pad. When it is high, the drive enable drops and the data lanes read zero, and the pipeline and the sequencer keep running. A synchronous reset empties the pipeline. After reset, no beat appears until a newly captured sample has crossed the full latency.

The sequencer has three states. `SEQ_IDLE` moves to `SEQ_HIGH` when a delayed sample arrives. `SEQ_HIGH` always moves to `SEQ_LOW`. `SEQ_LOW` returns to `SEQ_HIGH` if another delayed sample arrives in that cycle, and otherwise falls back to `SEQ_IDLE`. Reset forces `SEQ_IDLE`.

Top module: `sample_beat_formatter`

## Requirements
- R1: During and right after reset, `out_valid`, `out_hi`, `out_tag` and `out_data` are all zero.
- R2: A sample captured at clock edge e appears as the high beat right after edge e+LATENCY (LATENCY = 9 by default). In that beat, `out_data[7:0]` equals word bits 13..6.
- R3: In the clock that follows the high beat, the low beat puts word bits 5..0 on `out_data[7:2]`.
- R4: In the low beat, `out_data[1:0]` is zero.
- R5: `out_valid` is 1 in both beats and 0 in all other cycles. `out_hi` is 1 in the high beat and 0 in the low beat.
- R6: `out_tag` equals the tag captured with the sample during both of its beats.
- R7: While `oe_n` is 1, `out_drive` is 0 and `out_data` is zero, and this takes effect in the same cycle. Sequencing is not affected: a beat that falls in this window is not replayed later. While `oe_n` is 0, `out_drive` is 1.
- R8: In a cycle with no beat, `out_data` and `out_tag` are zero.
- R9: A synchronous reset discards every sample in flight, including samples strobed while reset is held. No beat appears from any of them.
- R10: Samples may be strobed every second clock. The low beat of one sample is then followed directly by the high beat of the next. Strobes on adjacent clocks are not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_word | input | 14 | Conversion result |
| in_tag | input | 2 | Channel tag of the result |
| oe_n | input | 1 | Output enable, active low |
| out_data | output | 8 | Beat data lanes |
| out_drive | output | 1 | Pad drive enable; 0 means the bus floats |
| out_valid | output | 1 | Beat present |
| out_hi | output | 1 | 1 for the high beat, 0 for the low beat |
| out_tag | output | 2 | Tag of the beat's sample |

## Verification
The bench sweeps several hundred word values, among them all-zero, all-one and the two alternating patterns. It mixes strobe gaps of two and three clocks. A pipeline that is one stage off puts every beat in the wrong cycle. Packing the low bits at the wrong end corrupts the low beat and leaves stray ones in the two lowest lanes. A sequencer that mishandles `SEQ_LOW` to `SEQ_HIGH` drops or duplicates the sample that follows at a two-clock gap. The bench also raises `oe_n` across beats and resets while samples are in flight. A design that stalls instead of discarding during high impedance, or one that keeps stale stages through reset, produces beats where none are expected.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HIGH = 2'd1,
        SEQ_LOW  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sbf_delay_line.sv
module sbf_delay_line #(
    parameter int PAY_W = 16,
    parameter int DEPTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_pay
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    for (genvar g = 0; g < DEPTH; g++) begin : stg
        logic             v_q;
        logic [PAY_W-1:0] p_q;
        if (g == 0) begin : head
            always_ff @(posedge clk) begin
                if (rst) v_q <= 1'b0;
                else     v_q <= in_valid;
                p_q <= in_pay;
            end
        end else begin : body
            always_ff @(posedge clk) begin
                if (rst) v_q <= 1'b0;
                else     v_q <= stg[g-1].v_q;
                p_q <= stg[g-1].p_q;
            end
        end
    end

    assign out_valid = stg[DEPTH-1].v_q;
    assign out_pay   = stg[DEPTH-1].p_q;

    // cycles since reset, saturating at DEPTH
    logic [CNT_W-1:0] fill_q;
    always_ff @(posedge clk) begin
        if (rst)                          fill_q <= '0;
        else if (fill_q < CNT_W'(DEPTH))  fill_q <= fill_q + 1'b1;
    end

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (fill_q < CNT_W'(DEPTH)) |-> !out_valid)
        else $error("pipeline produced a sample before refilling after reset");
endmodule

// File: rtl/sbf_beat_seq.sv
module sbf_beat_seq
    import sbf_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [WORD_W-1:0] arr_word,
    input  logic [TAG_W-1:0]  arr_tag,
    output logic              beat_valid,
    output logic              beat_hi,
    output logic [WORD_W-1:0] beat_word,
    output logic [TAG_W-1:0]  beat_tag
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [TAG_W-1:0]  tag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (arr_valid) state_d = SEQ_HIGH;
            SEQ_HIGH: state_d = SEQ_LOW;
            SEQ_LOW:  state_d = arr_valid ? SEQ_HIGH : SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            word_q  <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == SEQ_HIGH) begin
                word_q <= arr_word;
                tag_q  <= arr_tag;
            end
        end
    end

    always_comb begin
        beat_valid = 1'b0;
        beat_hi    = 1'b0;
        beat_word  = '0;
        beat_tag   = '0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_HIGH: begin
                beat_valid = 1'b1;
                beat_hi    = 1'b1;
                beat_word  = word_q;
                beat_tag   = tag_q;
            end
            SEQ_LOW: begin
                beat_valid = 1'b1;
                beat_word  = word_q;
                beat_tag   = tag_q;
            end
            default: ;
        endcase
    end

    assert_no_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_HIGH) |-> !arr_valid)
        else $error("delayed sample arrived during a high beat and would be lost");
endmodule

// File: rtl/sample_beat_formatter.sv
module sample_beat_formatter #(
    parameter int WORD_W  = 14,
    parameter int BUS_W   = 8,
    parameter int TAG_W   = 2,
    parameter int LATENCY = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              oe_n,
    output logic [BUS_W-1:0]  out_data,
    output logic              out_drive,
    output logic              out_valid,
    output logic              out_hi,
    output logic [TAG_W-1:0]  out_tag
);
    localparam int LO_W  = WORD_W - BUS_W;
    localparam int PAD_W = BUS_W - LO_W;
    localparam int PAY_W = TAG_W + WORD_W;

    logic              dl_valid;
    logic [PAY_W-1:0]  dl_pay;
    logic              bt_valid, bt_hi;
    logic [WORD_W-1:0] bt_word;
    logic [TAG_W-1:0]  bt_tag;
    logic [BUS_W-1:0]  hi_byte, lo_byte;

    sbf_delay_line #(.PAY_W(PAY_W), .DEPTH(LATENCY)) delay_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pay   ({in_tag, in_word}),
        .out_valid(dl_valid),
        .out_pay  (dl_pay)
    );

    sbf_beat_seq #(.WORD_W(WORD_W), .TAG_W(TAG_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .arr_valid (dl_valid),
        .arr_word  (dl_pay[WORD_W-1:0]),
        .arr_tag   (dl_pay[PAY_W-1:WORD_W]),
        .beat_valid(bt_valid),
        .beat_hi   (bt_hi),
        .beat_word (bt_word),
        .beat_tag  (bt_tag)
    );

    assign hi_byte = bt_word[WORD_W-1 -: BUS_W];
    if (PAD_W > 0) begin : g_pad
        assign lo_byte = {bt_word[LO_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
        assign lo_byte = bt_word[LO_W-1:0];
    end

    always_comb begin
        out_drive = !oe_n;
        out_valid = bt_valid;
        out_hi    = bt_hi;
        out_tag   = bt_tag;
        out_data  = '0;
        if (!oe_n && bt_valid) out_data = bt_hi ? hi_byte : lo_byte;
    end

    assert_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!out_drive && out_data == '0))
        else $error("bus driven while output enable is inactive");

    assert_low_pad_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hi) |-> (out_data[1:0] == 2'b00))
        else $error("low beat has ones in the pad lanes");

    // R6: tag stays put across the pair
    assert_beat_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hi) |=> (out_valid && !out_hi && $stable(out_tag)))
        else $error("high beat not followed by its low beat");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && out_tag == '0))
        else $error("idle cycle carries data");

    assert_strobe_gap_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid)
        else $error("sample strobes on adjacent clocks");
endmodule

// File: tb/sample_beat_formatter_tb_top.sv
module sample_beat_formatter_tb_top;
    localparam int LAT = 9;
    localparam int NE  = 8192;

    logic        clk = 1'b0;
    logic        rst, in_valid, oe_n;
    logic [13:0] in_word;
    logic [1:0]  in_tag;
    logic [7:0]  out_data;
    logic        out_drive, out_valid, out_hi;
    logic [1:0]  out_tag;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int          exp_kind [NE];
    logic [13:0] exp_word [NE];
    logic [1:0]  exp_tag  [NE];

    always #4 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    sample_beat_formatter #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_tag(in_tag), .oe_n(oe_n), .out_data(out_data),
        .out_drive(out_drive), .out_valid(out_valid), .out_hi(out_hi),
        .out_tag(out_tag)
    );

    task automatic check_cycle(input string req);
        logic [13:0] exp_v, act_v;
        logic [7:0]  ed;
        int          k;
        k  = exp_kind[edges];
        ed = 8'h00;
        if (!oe_n && k == 1) ed = exp_word[edges][13:6];
        if (!oe_n && k == 2) ed = {exp_word[edges][5:0], 2'b00};
        exp_v = {k != 0, k == 1, !oe_n, (k != 0) ? exp_tag[edges] : 2'b00, ed, 1'b0};
        act_v = {out_valid, out_hi, out_drive, out_tag, out_data, 1'b0};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s edge %0d: {valid,hi,drive,tag,data} actual %h expected %h",
                     (oe_n ? "R7" : (k == 1 ? "R2 R5 R6" : (k == 2 ? "R3 R4 R5 R6 R10" : req))),
                     edges, act_v, exp_v);
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [13:0] w,
                        input logic [1:0] t, input bit o, input string req);
        @(negedge clk);
        #1;
        if (edges > 0) check_cycle(req);
        rst = r; in_valid = v; in_word = w; in_tag = t; oe_n = o;
        if (r) begin
            for (int k = 0; k <= LAT + 1; k++) exp_kind[edges + 1 + k] = 0;
        end else if (v) begin
            exp_kind[edges + 1 + LAT] = 1;
            exp_kind[edges + 2 + LAT] = 2;
            exp_word[edges + 1 + LAT] = w;
            exp_word[edges + 2 + LAT] = w;
            exp_tag[edges + 1 + LAT]  = t;
            exp_tag[edges + 2 + LAT]  = t;
        end
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            exp_kind[i] = 0; exp_word[i] = '0; exp_tag[i] = '0;
        end
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_tag = '0; oe_n = 1'b0;
        // R1: reset, then quiet outputs
        for (int i = 0; i < 3; i++) step(1, 0, 14'h0, 2'd0, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, 0, 14'h0, 2'd0, 0, "R1");
        // Sweep: R2 R3 R4 R5 R6 R8 R10, with output-enable windows for R7
        for (int k = 0; k < 600; k++) begin
            logic [13:0] w;
            bit          o;
            int          gap;
            w = 14'((k * 1237 + 5) % 16384);
            if (k == 0) w = 14'h0000;
            if (k == 1) w = 14'h3FFF;
            if (k == 2) w = 14'h2AAA;
            if (k == 3) w = 14'h1555;
            o   = (k >= 200 && k < 230) || (k % 50 == 7);
            gap = (k % 4 == 0) ? 3 : 2;
            step(0, 1, w, 2'(k % 4), o, "R8");
            for (int g = 1; g < gap; g++) step(0, 0, 14'h0, 2'd0, o, "R8");
        end
        for (int i = 0; i < LAT + 4; i++) step(0, 0, 14'h0, 2'd0, 0, "R8");
        // R9: reset with samples in flight, plus strobes during reset
        step(0, 1, 14'h1234, 2'd1, 0, "R9");
        step(0, 0, 14'h0, 2'd0, 0, "R9");
        step(0, 1, 14'h0F0F, 2'd2, 0, "R9");
        for (int i = 0; i < LAT - 2; i++) step(0, 0, 14'h0, 2'd0, 0, "R9");
        step(1, 1, 14'h3C3C, 2'd3, 0, "R9");
        step(1, 0, 14'h0, 2'd0, 0, "R9");
        step(1, 1, 14'h2222, 2'd3, 0, "R9");
        for (int i = 0; i < LAT + 4; i++) step(0, 0, 14'h0, 2'd0, 0, "R9");
        // refill after reset: R2
        step(0, 1, 14'h2D4B, 2'd2, 0, "R8");
        for (int i = 0; i < LAT + 4; i++) step(0, 0, 14'h0, 2'd0, 0, "R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule